// File: doc/BRIEF.md
# Pipelined Three-Round Nonlinear Mixing Unit

This block is a 32-bit keyed nonlinear function. It is built as a three-round Feistel network. Each round calls a 16-bit subfunction, and that subfunction is itself a four-round Feistel network. Inside it, data moves along a 9-bit lane and a 7-bit lane, and each lane passes through its own substitution tables. An outer cipher engine calls the unit once per round. The engine supplies a 32-bit data word, a 48-bit block of mixing keys and a 48-bit block of subfunction keys, and it takes back a 32-bit result.

The twelve inner subfunction rounds are split evenly across four register stages. The unit therefore has a fixed latency of four cycles and takes a new block on every cycle. Up to four unrelated blocks, each with its own keys, can be in flight at the same time. Each stage registers the keys together with the data. As a result, an interleaved block always finishes with the keys it entered with. The substitution tables are not stored: they are computed from small field arithmetic.

Top module: `fo_pipe_unit`

## Requirements
- R1: Name the halves of `data_in` A (bits 31:16) and B (bits 15:0). For round j = 1, 2, 3, the mixing key Mj is `ko_in[63-16j -: 16]` and the subfunction key Kj is `ki_in[63-16j -: 16]`, so round 1 uses bits 47:32. Each round computes T = G(A xor Mj, Kj) xor B, then sets A = B and B = T. `result_out` is {A, B} after round 3.
- R2: The subfunction G(x, k) splits x into a 9-bit L = x[15:7] and a 7-bit R = x[6:0], and splits k into k7 = k[15:9] and k9 = k[8:0]. It then computes, in order:
  - R1' = S9(L) xor zero-extended R, and L1 = R.
  - R2' = S7(L1) xor R1'[6:0] xor k7, and L2 = R1' xor k9.
  - R3' = S9(L2) xor zero-extended R2', and L3 = R2'.
  - L4 = S7(L3) xor R3'[6:0], and R4 = R3'.
  
  G returns {L4, R4}.
- R3: S9(v) = v³ in GF(2⁹) reduced by x⁹+x⁴+1, xor 9'h0B3. S7(v) = v³ in GF(2⁷) reduced by x⁷+x+1, xor 7'h2D.
- R4: `valid_out` rises exactly four cycles after an accepted `valid_in`. The matching `result_out` is presented in that same cycle.
- R5: A block is accepted on every cycle with no stall. Back-to-back blocks with different keys each produce the result for their own data and keys.
- R6: Synchronous active-high `rst` clears all in-flight valid flags. `valid_out` is low during reset and stays low until a block accepted after reset reaches the output. Inputs presented with `valid_in` low never produce a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input block valid |
| data_in | input | 32 | Input data word |
| ko_in | input | 48 | Three 16-bit mixing keys, round 1 in the top bits |
| ki_in | input | 48 | Three 16-bit subfunction keys, round 1 in the top bits |
| valid_out | output | 1 | Result valid |
| result_out | output | 32 | Function result |

## Verification
Every result is due four clock edges after the edge that accepts its input. The bench models this as a four-deep shift of expected valid flags and reference results, advanced on each rising edge. At every falling edge it compares `valid_out` and, when valid, `result_out` against the last slot. A reset clears that model in the same edge as the design, so a reset in the middle of a stream must leave four empty output cycles behind it.

// File: rtl/fo_nl_pkg.sv
package fo_nl_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int WIDE_W   = 9;
    localparam int NARROW_W = 7;
    localparam int FO_ROUNDS = 3;
    localparam int FI_ROUNDS = 4;
    localparam int TOTAL_STEPS = FO_ROUNDS * FI_ROUNDS;
    localparam int KEY_W    = FO_ROUNDS * HALF_W;

    localparam logic [WIDE_W-1:0]   WIDE_POLY   = 9'h011;
    localparam logic [NARROW_W-1:0] NARROW_POLY = 7'h03;
    localparam logic [WIDE_W-1:0]   WIDE_MASK   = 9'h0B3;
    localparam logic [NARROW_W-1:0] NARROW_MASK = 7'h2D;

    typedef struct packed {
        logic [HALF_W-1:0]   lh;
        logic [HALF_W-1:0]   rh;
        logic [WIDE_W-1:0]   p;
        logic [NARROW_W-1:0] q;
    } fo_state_t;

    typedef struct packed {
        logic             vld;
        fo_state_t        st;
        logic [KEY_W-1:0] ko;
        logic [KEY_W-1:0] ki;
    } fo_slot_t;

    function automatic logic [WIDE_W-1:0] gf_wide_mul(input logic [WIDE_W-1:0] a,
                                                      input logic [WIDE_W-1:0] b);
        logic [WIDE_W-1:0] acc;
        logic [WIDE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < WIDE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[WIDE_W-2:0], 1'b0} ^ (sh[WIDE_W-1] ? WIDE_POLY : '0);
        end
        return acc;
    endfunction

    function automatic logic [NARROW_W-1:0] gf_narrow_mul(input logic [NARROW_W-1:0] a,
                                                          input logic [NARROW_W-1:0] b);
        logic [NARROW_W-1:0] acc;
        logic [NARROW_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < NARROW_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[NARROW_W-2:0], 1'b0} ^ (sh[NARROW_W-1] ? NARROW_POLY : '0);
        end
        return acc;
    endfunction

    function automatic logic [WIDE_W-1:0] sub_wide(input logic [WIDE_W-1:0] v);
        return gf_wide_mul(gf_wide_mul(v, v), v) ^ WIDE_MASK;
    endfunction

    function automatic logic [NARROW_W-1:0] sub_narrow(input logic [NARROW_W-1:0] v);
        return gf_narrow_mul(gf_narrow_mul(v, v), v) ^ NARROW_MASK;
    endfunction

    function automatic logic [HALF_W-1:0] key_part(input logic [KEY_W-1:0] k, input int j);
        return k[KEY_W-1-HALF_W*j -: HALF_W];
    endfunction

    // One inner subfunction round; step k covers outer round k/4, inner round k%4.
    function automatic fo_state_t fo_step(input fo_state_t s, input int k,
                                          input logic [KEY_W-1:0] ko,
                                          input logic [KEY_W-1:0] ki);
        fo_state_t         n;
        logic [HALF_W-1:0] x;
        logic [HALF_W-1:0] kj;
        logic [HALF_W-1:0] fi;
        n  = s;
        kj = key_part(ki, k / FI_ROUNDS);
        case (k % FI_ROUNDS)
            0: begin
                x   = s.lh ^ key_part(ko, k / FI_ROUNDS);
                n.q = x[NARROW_W-1:0];
                n.p = sub_wide(x[HALF_W-1:NARROW_W]) ^ {2'b00, x[NARROW_W-1:0]};
            end
            1: begin
                n.p = s.p ^ kj[WIDE_W-1:0];
                n.q = sub_narrow(s.q) ^ s.p[NARROW_W-1:0] ^ kj[HALF_W-1:WIDE_W];
            end
            2: begin
                n.p = sub_wide(s.p) ^ {2'b00, s.q};
            end
            default: begin
                fi   = {sub_narrow(s.q) ^ s.p[NARROW_W-1:0], s.p};
                n.lh = s.rh;
                n.rh = fi ^ s.rh;
            end
        endcase
        return n;
    endfunction

    // Round-structured model used by the checker.
    function automatic logic [HALF_W-1:0] fi_model(input logic [HALF_W-1:0] x,
                                                   input logic [HALF_W-1:0] k);
        logic [WIDE_W-1:0]   a;
        logic [NARROW_W-1:0] b;
        a = sub_wide(x[HALF_W-1:NARROW_W]) ^ {2'b00, x[NARROW_W-1:0]};
        b = x[NARROW_W-1:0];
        b = sub_narrow(b) ^ a[NARROW_W-1:0] ^ k[HALF_W-1:WIDE_W];
        a = a ^ k[WIDE_W-1:0];
        a = sub_wide(a) ^ {2'b00, b};
        b = sub_narrow(b) ^ a[NARROW_W-1:0];
        return {b, a};
    endfunction

    function automatic logic [WORD_W-1:0] fo_model(input logic [WORD_W-1:0] d,
                                                   input logic [KEY_W-1:0] ko,
                                                   input logic [KEY_W-1:0] ki);
        logic [HALF_W-1:0] l;
        logic [HALF_W-1:0] r;
        logic [HALF_W-1:0] t;
        l = d[WORD_W-1:HALF_W];
        r = d[HALF_W-1:0];
        for (int j = 0; j < FO_ROUNDS; j++) begin
            t = fi_model(l ^ key_part(ko, j), key_part(ki, j)) ^ r;
            l = r;
            r = t;
        end
        return {l, r};
    endfunction

endpackage

// File: rtl/fo_stage.sv
module fo_stage
    import fo_nl_pkg::*;
#(
    parameter int FIRST_STEP = 0,
    parameter int NUM_STEPS  = 3
) (
    input  fo_slot_t slot_in,
    output fo_slot_t slot_out
);
    fo_state_t chain [NUM_STEPS+1];

    assign chain[0] = slot_in.st;

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        assign chain[i+1] = fo_step(chain[i], FIRST_STEP + i, slot_in.ko, slot_in.ki);
    end

    always_comb begin
        slot_out    = slot_in;
        slot_out.st = chain[NUM_STEPS];
    end
endmodule

// File: rtl/fo_pipe_reg.sv
module fo_pipe_reg
    import fo_nl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fo_slot_t d,
    output fo_slot_t q
);
    always_ff @(posedge clk) begin
        q.st <= d.st;
        q.ko <= d.ko;
        q.ki <= d.ki;
        if (rst) q.vld <= 1'b0;
        else     q.vld <= d.vld;
    end
endmodule

// File: rtl/fo_pipe_unit.sv
module fo_pipe_unit
    import fo_nl_pkg::*;
#(
    parameter int NUM_STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [WORD_W-1:0] data_in,
    input  logic [KEY_W-1:0]  ko_in,
    input  logic [KEY_W-1:0]  ki_in,
    output logic              valid_out,
    output logic [WORD_W-1:0] result_out
);
    localparam int STEPS_PER_STAGE = TOTAL_STEPS / NUM_STAGES;

    fo_slot_t head;
    fo_slot_t comb_q [NUM_STAGES];
    fo_slot_t reg_q  [NUM_STAGES+1];

    always_comb begin
        head.vld  = valid_in;
        head.st.lh = data_in[WORD_W-1:HALF_W];
        head.st.rh = data_in[HALF_W-1:0];
        head.st.p  = '0;
        head.st.q  = '0;
        head.ko   = ko_in;
        head.ki   = ki_in;
    end

    assign reg_q[0] = head;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        fo_stage #(
            .FIRST_STEP(s * STEPS_PER_STAGE),
            .NUM_STEPS (STEPS_PER_STAGE)
        ) u_stage (
            .slot_in (reg_q[s]),
            .slot_out(comb_q[s])
        );
        fo_pipe_reg u_reg (
            .clk(clk),
            .rst(rst),
            .d  (comb_q[s]),
            .q  (reg_q[s+1])
        );
    end

    assign valid_out  = reg_q[NUM_STAGES].vld;
    assign result_out = {reg_q[NUM_STAGES].st.lh, reg_q[NUM_STAGES].st.rh};
endmodule

// File: rtl/fo_pipe_chk.sv
module fo_pipe_chk
    import fo_nl_pkg::*;
#(
    parameter int NUM_STAGES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [WORD_W-1:0] data_in,
    input logic [KEY_W-1:0]  ko_in,
    input logic [KEY_W-1:0]  ki_in,
    input logic              valid_out,
    input logic [WORD_W-1:0] result_out
);
    logic              h_vld [NUM_STAGES];
    logic [WORD_W-1:0] h_res [NUM_STAGES];
    logic              rst_q;

    always_ff @(posedge clk) begin
        rst_q    <= rst;
        h_res[0] <= fo_model(data_in, ko_in, ki_in);
        h_vld[0] <= rst ? 1'b0 : valid_in;
        for (int i = 1; i < NUM_STAGES; i++) begin
            h_res[i] <= h_res[i-1];
            h_vld[i] <= rst ? 1'b0 : h_vld[i-1];
        end
    end

    // R4, R6: output valid tracks input valid delayed by the pipeline depth
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst || rst_q)
        valid_out == h_vld[NUM_STAGES-1]);

    // R1, R2, R3, R5: each valid result matches the round-structured model
    assert_result_R5: assert property (@(posedge clk) disable iff (rst || rst_q)
        valid_out |-> result_out == h_res[NUM_STAGES-1]);

    assert_known_R4: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(valid_out));

    // R6: the edge after a reset cycle leaves the output invalid
    always @(posedge clk) begin
        if (rst_q) assert_reset_R6: assert (!valid_out);
    end
endmodule

bind fo_pipe_unit fo_pipe_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .data_in   (data_in),
    .ko_in     (ko_in),
    .ki_in     (ki_in),
    .valid_out (valid_out),
    .result_out(result_out)
);

// File: tb/fo_pipe_unit_tb.sv
`timescale 1ns/1ps
module fo_pipe_unit_tb;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] data_in = '0;
    logic [47:0] ko_in = '0;
    logic [47:0] ki_in = '0;
    logic        valid_out;
    logic [31:0] result_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fo_pipe_unit u_dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in),
        .ko_in(ko_in), .ki_in(ki_in), .valid_out(valid_out), .result_out(result_out)
    );

    // Independent reference (R1, R2, R3)
    function automatic logic [8:0] mul9(input logic [8:0] a, input logic [8:0] b);
        logic [17:0] prod = '0;
        for (int i = 0; i < 9; i++) if (b[i]) prod = prod ^ (18'(a) << i);
        for (int i = 17; i >= 9; i--) if (prod[i]) prod = prod ^ (18'h211 << (i - 9));
        return prod[8:0];
    endfunction
    function automatic logic [6:0] mul7(input logic [6:0] a, input logic [6:0] b);
        logic [13:0] prod = '0;
        for (int i = 0; i < 7; i++) if (b[i]) prod = prod ^ (14'(a) << i);
        for (int i = 13; i >= 7; i--) if (prod[i]) prod = prod ^ (14'h083 << (i - 7));
        return prod[6:0];
    endfunction
    function automatic logic [8:0] s9(input logic [8:0] v);
        return mul9(v, mul9(v, v)) ^ 9'h0B3;
    endfunction
    function automatic logic [6:0] s7(input logic [6:0] v);
        return mul7(v, mul7(v, v)) ^ 7'h2D;
    endfunction
    function automatic logic [15:0] ref_g(input logic [15:0] x, input logic [15:0] k);
        logic [8:0] l0, r1, l2, r3;
        logic [6:0] r0, l1, r2, l3, l4;
        l0 = x[15:7]; r0 = x[6:0];
        r1 = s9(l0) ^ {2'b00, r0}; l1 = r0;
        r2 = s7(l1) ^ r1[6:0] ^ k[15:9]; l2 = r1 ^ k[8:0];
        r3 = s9(l2) ^ {2'b00, r2}; l3 = r2;
        l4 = s7(l3) ^ r3[6:0];
        return {l4, r3};
    endfunction
    function automatic logic [31:0] ref_fo(input logic [31:0] d, input logic [47:0] ko,
                                           input logic [47:0] ki);
        logic [15:0] a = d[31:16];
        logic [15:0] b = d[15:0];
        logic [15:0] t;
        for (int j = 1; j <= 3; j++) begin
            t = ref_g(a ^ ko[63-16*j -: 16], ki[63-16*j -: 16]) ^ b;
            a = b;
            b = t;
        end
        return {a, b};
    endfunction

    // Expected-value pipeline, one slot per register stage (R4)
    logic        ev [LAT];
    logic [31:0] ed [LAT];
    always @(posedge clk) begin
        started <= 1'b1;
        for (int i = LAT - 1; i > 0; i--) begin
            ev[i] <= rst ? 1'b0 : ev[i-1];
            ed[i] <= ed[i-1];
        end
        ev[0] <= rst ? 1'b0 : valid_in;
        ed[0] <= ref_fo(data_in, ko_in, ki_in);
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (valid_out !== ev[LAT-1]) begin
                fails++;
                $display("FAIL R4 R6 valid_out cycle %0d: actual %b expected %b",
                         cyc, valid_out, ev[LAT-1]);
            end
            if (ev[LAT-1]) begin
                checks++;
                if (result_out !== ed[LAT-1]) begin
                    fails++;
                    $display("FAIL R1 R2 R3 R5 result cycle %0d: actual %h expected %h",
                             cyc, result_out, ed[LAT-1]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drive(input logic v, input logic [31:0] d,
                         input logic [47:0] ko, input logic [47:0] ki);
        valid_in = v; data_in = d; ko_in = ko; ki_in = ki;
        @(negedge clk);
    endtask

    task automatic drive_rand(input logic v);
        drive(v, $urandom, {$urandom, $urandom}, {$urandom, $urandom});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 10; i++) ev[i % LAT] = 1'b0;
        repeat (3) @(negedge clk);
        // R6: reset state, junk on inputs with valid low
        checks++;
        if (valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R6 reset valid_out: actual %b expected 0", valid_out);
        end
        rst = 1'b0;
        // R1 R2 R3 directed corners
        drive(1'b1, 32'h0, 48'h0, 48'h0);
        drive(1'b1, 32'hFFFF_FFFF, {48{1'b1}}, {48{1'b1}});
        drive(1'b1, 32'h8000_0001, 48'h0001_0000_8000, 48'h0180_007F_FE00);
        drive(1'b0, 32'h0, 48'h0, 48'h0);
        // R6: garbage with valid low must not emit
        for (int i = 0; i < 8; i++) drive_rand(1'b0);
        // R5: back-to-back distinct keys, then gapped traffic
        for (int i = 0; i < 300; i++) drive_rand(1'b1);
        for (int i = 0; i < 400; i++) drive_rand(($urandom % 3) != 0);
        // R6: reset in the middle of a full pipeline
        for (int i = 0; i < 3; i++) drive_rand(1'b1);
        rst = 1'b1;
        drive_rand(1'b1);
        drive_rand(1'b1);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) drive_rand(1'b0);
        for (int i = 0; i < 50; i++) drive_rand(1'b1);
        drive(1'b0, 32'h0, 48'h0, 48'h0);
        repeat (LAT + 2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule